// File: doc/BRIEF.md
# Timed And Indefinite Sleep Controller

This block decides when a sensor core is asleep and when it wakes. Software writes one control word, and the controller acts on its low nine bits. A nonzero value in the low eight bits starts a timed sleep that lasts that many half-second units. A prescaler supplies the half-second unit by dividing the core clock by a parameter. Bit 8 starts an indefinite sleep with no timeout.

Two events end a sleep. A timed sleep ends when its count runs out. Either kind of sleep ends on a high-to-low transition of the active-low chip-select line, which is synchronised first. Reset also forces the block awake.

While a sleep is in progress, `sleep_active` stays high. At the moment the block wakes, `wake_pulse` goes high for exactly one clock. Gating of power or clocks is left to the logic that uses these two outputs.

Top module: `sleep_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `sleep_active` and `wake_pulse` are both 0.
- R2: A write with bit 8 set makes `sleep_active` high from the next rising edge. Bits 7:0 of that write are ignored, so an indefinite sleep takes precedence over a timed sleep requested in the same write.
- R3: An indefinite sleep has no timeout. It ends only on a falling edge of `cs_n` or on reset. The wake takes effect SYNC_STAGES edges after the first rising edge that samples `cs_n` low.
- R4: A write with bit 8 clear and a nonzero value n in bits 7:0 starts a timed sleep at edge w, the edge that accepts the write. `sleep_active` is high after edge w and falls at edge w + n*HALF_SEC_CLKS.
- R5: Every wake drops `sleep_active` and raises `wake_pulse` at the same edge. `wake_pulse` stays high for exactly one cycle.
- R6: A write with bits 8:0 all zero has no effect. While the block is awake, it stays awake and no pulse is produced.
- R7: Bits 15:9 of the written word are ignored. For example, 0xFE00 does nothing, and 0xFE02 gives a timed sleep of 2 units.
- R8: A falling edge of `cs_n` during a timed sleep ends it early, with the same latency as in R3.
- R9: A falling edge of `cs_n` while the block is awake produces no pulse and no sleep.
- R10: Asserting reset during a sleep clears `sleep_active` at once and produces no `wake_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle strobe for a write to the sleep control word |
| wr_data | input | DATA_W | Written word; bit 8 requests indefinite sleep, bits 7:0 set the timed-sleep count |
| cs_n | input | 1 | Active-low chip select; its falling edge is the wake event |
| sleep_active | output | 1 | High while a sleep of either kind is in progress |
| wake_pulse | output | 1 | One-cycle pulse at the moment of waking |

## Verification
A write shows on `sleep_active` one edge after it is accepted, because only the state register lies in that path. A timed sleep of n units ends exactly n*HALF_SEC_CLKS edges after the accepting edge. A chip-select wake lands SYNC_STAGES edges after the first edge that sees `cs_n` low, because of the synchroniser and the edge register.

The bench drives inputs on falling edges and samples 1 ns after a chosen rising edge. It counts the edges up to each due point. It checks the cycle just before each due edge, to catch an early wake, and the due edge itself, to catch a late one.

// File: rtl/sleep_pkg.sv
package sleep_pkg;

   typedef enum logic [1:0] {
      ST_AWAKE = 2'b00,
      ST_TIMED = 2'b01,
      ST_INDEF = 2'b10
   } sleep_state_t;

   localparam int unsigned CTL_INDEF_BIT = 8;
   localparam int unsigned CTL_TIME_W    = 8;

endpackage

// File: rtl/sleep_prescaler.sv
module sleep_prescaler #(
   parameter int unsigned HALF_SEC_CLKS = 125_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic clr,
   output logic tick
);
   localparam int unsigned PW = (HALF_SEC_CLKS > 1) ? $clog2(HALF_SEC_CLKS) : 1;
   localparam logic [PW-1:0] LAST = PW'(HALF_SEC_CLKS - 1);

   if (HALF_SEC_CLKS < 1) begin : g_bad_div
      $error("HALF_SEC_CLKS must be at least 1");
   end

   logic [PW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr || !run)
         cnt_q <= '0;
      else if (cnt_q == LAST)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end

   assign tick = run && !clr && (cnt_q == LAST);

endmodule

// File: rtl/sleep_cs_edge.sv
module sleep_cs_edge #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   output logic cs_fall
);
   logic cs_s;
   logic prev_q;

   if (SYNC_STAGES == 0) begin : g_raw
      assign cs_s = cs_n;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain_q <= '1;
         end else begin
            for (int i = SYNC_STAGES - 1; i > 0; i--)
               chain_q[i] <= chain_q[i-1];
            chain_q[0] <= cs_n;
         end
      end
      assign cs_s = chain_q[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         prev_q <= 1'b1;
      else
         prev_q <= cs_s;
   end

   assign cs_fall = prev_q && !cs_s;

endmodule

// File: rtl/sleep_countdown.sv
module sleep_countdown #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   input  logic             clear,
   output logic             last
);
   if (CNT_W < 1) begin : g_bad_w
      $error("CNT_W must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (clear)
         cnt_q <= '0;
      else if (dec && cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign last = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/sleep_ctrl.sv
module sleep_ctrl
   import sleep_pkg::*;
#(
   parameter int unsigned DATA_W        = 16,
   parameter int unsigned HALF_SEC_CLKS = 125_000_000,
   parameter int unsigned SYNC_STAGES   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              cs_n,
   output logic              sleep_active,
   output logic              wake_pulse
);
   if (DATA_W < CTL_INDEF_BIT + 1) begin : g_bad_data_w
      $error("DATA_W must hold the indefinite-sleep bit");
   end

   sleep_state_t state_q, state_d;
   logic         req_indef, req_timed, accept;
   logic         cs_fall, tick, cnt_last, wake_ev;
   logic         pulse_q;
   logic [CTL_TIME_W-1:0] time_val;

   assign time_val  = wr_data[CTL_TIME_W-1:0];
   assign req_indef = wr_en && wr_data[CTL_INDEF_BIT];
   assign req_timed = wr_en && !wr_data[CTL_INDEF_BIT] && (time_val != '0);
   assign accept    = req_indef || req_timed;

   sleep_cs_edge #(.SYNC_STAGES(SYNC_STAGES)) u_cs_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs_n    (cs_n),
      .cs_fall (cs_fall)
   );

   sleep_prescaler #(.HALF_SEC_CLKS(HALF_SEC_CLKS)) u_presc (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (state_q == ST_TIMED),
      .clr   (accept),
      .tick  (tick)
   );

   sleep_countdown #(.CNT_W(CTL_TIME_W)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (req_timed),
      .load_val (time_val),
      .dec      (tick && (state_q == ST_TIMED) && !accept),
      .clear    (req_indef || wake_ev),
      .last     (cnt_last)
   );

   always_comb begin
      wake_ev = (state_q != ST_AWAKE) && !accept &&
                (cs_fall || ((state_q == ST_TIMED) && tick && cnt_last));
      state_d = state_q;
      if (req_indef)
         state_d = ST_INDEF;
      else if (req_timed)
         state_d = ST_TIMED;
      else if (wake_ev)
         state_d = ST_AWAKE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_AWAKE;
         pulse_q <= 1'b0;
      end else begin
         state_q <= state_d;
         pulse_q <= wake_ev;
      end
   end

   assign sleep_active = (state_q != ST_AWAKE);
   assign wake_pulse   = pulse_q;

endmodule

// File: rtl/sleep_ctrl_chk.sv
module sleep_ctrl_chk
   import sleep_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [DATA_W-1:0] wr_data,
   input logic              cs_fall,
   input sleep_state_t      st,
   input logic              sleep_active,
   input logic              wake_pulse
);

   assert_indef_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[CTL_INDEF_BIT]) |=> (st == ST_INDEF && sleep_active));

   assert_indef_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_INDEF && !cs_fall && !wr_en) |=> (st == ST_INDEF));

   assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |=> !wake_pulse);

   assert_fall_gives_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sleep_active) |-> wake_pulse);

   assert_pulse_awake_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |-> !sleep_active);

   assert_zero_write_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep_active && wr_en && wr_data[CTL_INDEF_BIT:0] == '0)
      |=> (!sleep_active && !wake_pulse));

   assert_awake_cs_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep_active && !wr_en) |=> (!sleep_active && !wake_pulse));

endmodule

bind sleep_ctrl sleep_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_en        (wr_en),
   .wr_data      (wr_data),
   .cs_fall      (cs_fall),
   .st           (state_q),
   .sleep_active (sleep_active),
   .wake_pulse   (wake_pulse)
);

// File: tb/sleep_ctrl_tb.sv
`timescale 1ns/1ps
module sleep_ctrl_tb;
   localparam int unsigned DW  = 16;
   localparam int unsigned DIV = 4;
   localparam int unsigned SYN = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          cs_n = 1'b1;
   logic          sleep_active, wake_pulse;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   sleep_ctrl #(.DATA_W(DW), .HALF_SEC_CLKS(DIV), .SYNC_STAGES(SYN)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .cs_n(cs_n), .sleep_active(sleep_active), .wake_pulse(wake_pulse)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic chk_out(input string req, input logic s_exp, input logic p_exp);
      chk({req, " sleep_active"}, sleep_active, s_exp);
      chk({req, " wake_pulse"}, wake_pulse, p_exp);
   endtask

   task automatic step(input int k);
      repeat (k) @(posedge clk);
      #1;
   endtask

   task automatic do_write(input logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = d;
      @(posedge clk);
      #1;
      wr_en = 1'b0;
      wr_data = '0;
   endtask

   // cs_n drops before edge k; wake due at edge k+SYN
   task automatic cs_drop_and_wake(input string req);
      @(negedge clk);
      cs_n = 1'b0;
      step(SYN);
      chk_out({req, " pre-wake"}, 1'b1, 1'b0);
      step(1);
      chk_out({req, " wake"}, 1'b0, 1'b1);
      @(negedge clk);
      cs_n = 1'b1;
      step(1);
      chk_out({req, " post"}, 1'b0, 1'b0);
   endtask

   task automatic t_reset();
      #1;
      chk_out("R1 in reset", 1'b0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      step(1);
      chk_out("R1 after reset", 1'b0, 1'b0);
   endtask

   task automatic t_timed(input int n, input logic [DW-1:0] word, input string req);
      do_write(word);
      chk_out({req, " entry"}, 1'b1, 1'b0);
      step(n * DIV - 1);
      chk_out({req, " last asleep cycle"}, 1'b1, 1'b0);
      step(1);
      chk_out({req, " expiry"}, 1'b0, 1'b1);
      step(1);
      chk_out({req, " R5 pulse width"}, 1'b0, 1'b0);
   endtask

   task automatic t_indef_precedence();
      do_write(16'h0105);
      chk_out("R2 indefinite entry", 1'b1, 1'b0);
      step(40);
      chk_out("R3 no timeout", 1'b1, 1'b0);
      cs_drop_and_wake("R3 cs wake");
   endtask

   task automatic t_zero_write();
      do_write(16'h0000);
      chk_out("R6 zero write", 1'b0, 1'b0);
      step(10);
      chk_out("R6 still awake", 1'b0, 1'b0);
   endtask

   task automatic t_upper_bits();
      do_write(16'hFE00);
      chk_out("R7 upper bits only", 1'b0, 1'b0);
      step(3);
      chk_out("R7 still awake", 1'b0, 1'b0);
      t_timed(2, 16'hFE02, "R7 timed 2");
   endtask

   task automatic t_early_wake();
      do_write(16'h0020);
      chk_out("R8 entry", 1'b1, 1'b0);
      step(5);
      cs_drop_and_wake("R8 early wake");
   endtask

   task automatic t_awake_cs();
      @(negedge clk);
      cs_n = 1'b0;
      for (int i = 0; i < SYN + 3; i++) begin
         step(1);
         chk_out("R9 awake cs fall", 1'b0, 1'b0);
      end
      @(negedge clk);
      cs_n = 1'b1;
   endtask

   task automatic t_reset_in_sleep();
      do_write(16'h0100);
      chk_out("R10 asleep", 1'b1, 1'b0);
      step(3);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk_out("R10 reset in sleep", 1'b0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      step(1);
      chk_out("R10 after release", 1'b0, 1'b0);
   endtask

   initial begin
      t_reset();
      t_timed(3, 16'h0003, "R4 timed 3");
      t_timed(1, 16'h0001, "R4 timed 1");
      t_indef_precedence();
      t_zero_write();
      t_upper_bits();
      t_early_wake();
      t_awake_cs();
      t_reset_in_sleep();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R1..all: actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule